// File: doc/BRIEF.md
# Flash Host Bus Command Front End

This block is the host-facing side of a word-wide NOR-style flash memory. The asynchronous pins are chip select, output gate and write strobe (all active low), plus an address bus and a data bus. The data bus is split into an input, an output and an output-enable. The block samples every pin on its own clock. It turns each write cycle into one command word, and it answers read cycles from one of two sources: a small internal word array, or a set of identification codes.

A write cycle is the interval during which chip select and write strobe are both low while the output gate is high. The address is taken when that combined strobe begins, which is when the later of the two enables falls. The data is taken when the strobe ends, which is when the earlier of the two rises. The commands do not go to any memory location. A three-write unlock sequence moves the block into identification mode. In that mode, reads of four fixed addresses return a manufacturer code and a device code. The device code announces that two extended codes follow. A reset command returns the block to array reads.

Top module: `flash_cmd_latch`

## Requirements
- R1: A write cycle is taken only while chip select and write strobe are low and the output gate is high. Low strobes with the output gate low issue no command.
- R2: The command address is the address present on the clock where the combined strobe (chip select OR write strobe, active low) first becomes active. This is the later of the two falling edges. Later address changes inside the cycle are ignored.
- R3: The command data is the data present on the clock where the combined strobe becomes inactive. This is the earlier of the two rising edges. Earlier and later data values are ignored.
- R4: dq_oe is high one clock after a sample in which chip select and output gate are low and write strobe is high. After any other sample it is low.
- R5: When the output gate is high, dq_oe is low and dq_out is 0000h.
- R6: The command bytes (low 8 data bits) AAh to 555h, then 55h to 2AAh, then 90h to 555h enter identification mode. Only the low 11 address bits are compared.
- R7: Any write that does not match the next step of the unlock sequence returns the sequence to its start. An interrupted sequence does not enter identification mode.
- R8: The command byte F0h, written to any address, leaves identification mode and clears the unlock sequence.
- R9: In identification mode, a read of address 000h returns the manufacturer code (default 0004h).
- R10: In identification mode, a read of address 001h returns the device code (default 227Eh).
- R11: In identification mode, reads of 00Eh and 00Fh return the first and second extended codes (defaults 2210h and 2200h). Any other address returns 0000h.
- R12: In array mode, a read returns word A500h plus the index formed by the low 4 address bits.
- R13: After reset the block is in array mode with the unlock sequence at its start and dq_oe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 12 | Word address |
| dq_in | input | 16 | Data bus, host to device |
| dq_out | output | 16 | Data bus, device to host (0 when not driven) |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
A wrong unlock state does not show up on a write. It shows up on the first read after the third unlock write: that read returns an array word where an identification code was expected, or the reverse, one clock after the read is presented. A strobe captured on the wrong edge does the same thing, because the command carries the wrong address or data, so the unlock fails or succeeds when it should not. The bench therefore makes the address and the data change inside the write cycle. It then judges each capture edge by the mode that the next read reveals.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_ONE  = 2'd1,
        UL_TWO  = 2'd2
    } unlock_e;

    localparam int unsigned CMD_W       = 8;
    localparam int unsigned MATCH_W     = 11;
    localparam logic [7:0]  CMD_KEY_A   = 8'hAA;
    localparam logic [7:0]  CMD_KEY_B   = 8'h55;
    localparam logic [7:0]  CMD_IDENT   = 8'h90;
    localparam logic [7:0]  CMD_EXIT    = 8'hF0;
    localparam logic [10:0] KEY_ADDR_A  = 11'h555;
    localparam logic [10:0] KEY_ADDR_B  = 11'h2AA;

    function automatic logic [15:0] array_word(int unsigned idx);
        return 16'hA500 + 16'(idx);
    endfunction

endpackage

// File: rtl/fb_strobe.sv
module fb_strobe #(
    parameter int unsigned AW = 12,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic          cmd_vld,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_data
);

    typedef struct packed {
        logic          act;
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } strobe_t;

    strobe_t st_d, st_q;
    logic    wr_act;

    // combined strobe: active only while both enables are low and the gate is high
    assign wr_act = ~ce_n & ~we_n & oe_n;

    always_comb begin
        st_d     = st_q;
        st_d.act = wr_act;
        st_d.vld = 1'b0;
        if (wr_act && !st_q.act) begin
            st_d.addr = addr;
        end
        if (!wr_act && st_q.act) begin
            st_d.vld  = 1'b1;
            st_d.data = dq_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_vld  = st_q.vld;
    assign cmd_addr = st_q.addr;
    assign cmd_data = st_q.data;

endmodule

// File: rtl/fb_cmd_fsm.sv
module fb_cmd_fsm
    import flash_bus_pkg::*;
#(
    parameter int unsigned AW = 12,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_vld,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    output logic          auto_mode
);

    typedef struct packed {
        unlock_e ul;
        logic    auto_on;
    } fsm_t;

    fsm_t st_d, st_q;

    logic [CMD_W-1:0]   op;
    logic [MATCH_W-1:0] key_addr;
    logic               unused_hi;

    assign op        = cmd_data[CMD_W-1:0];
    assign key_addr  = cmd_addr[MATCH_W-1:0];
    assign unused_hi = ^{cmd_data[DW-1:CMD_W], cmd_addr[AW-1:MATCH_W]};

    always_comb begin
        st_d = st_q;
        if (cmd_vld) begin
            if (op == CMD_EXIT) begin
                st_d.ul      = UL_IDLE;
                st_d.auto_on = 1'b0;
            end else begin
                unique case (st_q.ul)
                    UL_IDLE: st_d.ul = (op == CMD_KEY_A && key_addr == KEY_ADDR_A) ? UL_ONE : UL_IDLE;
                    UL_ONE:  st_d.ul = (op == CMD_KEY_B && key_addr == KEY_ADDR_B) ? UL_TWO : UL_IDLE;
                    UL_TWO: begin
                        st_d.ul = UL_IDLE;
                        if (op == CMD_IDENT && key_addr == KEY_ADDR_A) begin
                            st_d.auto_on = 1'b1;
                        end
                    end
                    default: st_d.ul = UL_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ul: UL_IDLE, auto_on: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign auto_mode = st_q.auto_on;

endmodule

// File: rtl/fb_read_port.sv
module fb_read_port
    import flash_bus_pkg::*;
#(
    parameter int unsigned AW       = 12,
    parameter int unsigned DW       = 16,
    parameter int unsigned DEPTH    = 16,
    parameter logic [15:0] MFR_CODE = 16'h0004,
    parameter logic [15:0] DEV_CODE = 16'h227E,
    parameter logic [15:0] EXT_ONE  = 16'h2210,
    parameter logic [15:0] EXT_TWO  = 16'h2200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic          auto_mode,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);

    localparam int unsigned IW = $clog2(DEPTH);

    typedef struct packed {
        logic          oe;
        logic [DW-1:0] data;
    } rd_t;

    rd_t           st_d, st_q;
    logic [DW-1:0] words [DEPTH];
    logic [DW-1:0] id_word;
    logic          rd_sel;

    for (genvar g = 0; g < DEPTH; g++) begin : g_words
        assign words[g] = DW'(array_word(g));
    end

    always_comb begin
        if (addr == AW'(0)) begin
            id_word = DW'(MFR_CODE);
        end else if (addr == AW'(1)) begin
            id_word = DW'(DEV_CODE);
        end else if (addr == AW'(14)) begin
            id_word = DW'(EXT_ONE);
        end else if (addr == AW'(15)) begin
            id_word = DW'(EXT_TWO);
        end else begin
            id_word = '0;
        end
    end

    assign rd_sel = ~ce_n & ~oe_n & we_n;

    always_comb begin
        st_d.oe   = rd_sel;
        st_d.data = '0;
        if (rd_sel) begin
            st_d.data = auto_mode ? id_word : words[addr[IW-1:0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_out = st_q.data;
    assign dq_oe  = st_q.oe;

endmodule

// File: rtl/flash_cmd_latch.sv
module flash_cmd_latch #(
    parameter int unsigned AW       = 12,
    parameter int unsigned DW       = 16,
    parameter int unsigned DEPTH    = 16,
    parameter logic [15:0] MFR_CODE = 16'h0004,
    parameter logic [15:0] DEV_CODE = 16'h227E,
    parameter logic [15:0] EXT_ONE  = 16'h2210,
    parameter logic [15:0] EXT_TWO  = 16'h2200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);

    logic          cmd_vld;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic          auto_mode;

    fb_strobe #(.AW(AW), .DW(DW)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .addr     (addr),
        .dq_in    (dq_in),
        .cmd_vld  (cmd_vld),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data)
    );

    fb_cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_vld   (cmd_vld),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .auto_mode (auto_mode)
    );

    fb_read_port #(
        .AW(AW), .DW(DW), .DEPTH(DEPTH),
        .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE),
        .EXT_ONE(EXT_ONE), .EXT_TWO(EXT_TWO)
    ) u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .addr      (addr),
        .auto_mode (auto_mode),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

endmodule

// File: rtl/flash_cmd_latch_chk.sv
module flash_cmd_latch_chk #(
    parameter int unsigned AW       = 12,
    parameter int unsigned DW       = 16,
    parameter logic [15:0] MFR_CODE = 16'h0004,
    parameter logic [15:0] DEV_CODE = 16'h227E
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          we_n,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] dq_out,
    input logic          dq_oe,
    input logic          cmd_vld,
    input logic [7:0]    cmd_lo,
    input logic          auto_mode
);

    // R4: a read sample drives the bus on the next clock
    p_read_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n) |=> dq_oe);

    // R5: gate high means no drive and a zero output on the next clock
    p_gate_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (!dq_oe && dq_out == '0));

    // R3: a write cycle yields exactly one command pulse
    p_cmd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld |=> !cmd_vld);

    // R6: the mode moves only on a command
    p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld |=> $stable(auto_mode));

    // R8: exit byte leaves identification mode
    p_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_lo == 8'hF0) |=> !auto_mode);

    // R9: manufacturer code at word 0
    p_mfr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n && auto_mode && addr == '0) |=> (dq_out == DW'(MFR_CODE)));

    // R10: device code at word 1
    p_dev_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n && auto_mode && addr == AW'(1)) |=> (dq_out == DW'(DEV_CODE)));

endmodule

bind flash_cmd_latch flash_cmd_latch_chk #(
    .AW(AW), .DW(DW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .addr      (addr),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .cmd_vld   (cmd_vld),
    .cmd_lo    (cmd_data[7:0]),
    .auto_mode (auto_mode)
);

// File: tb/test_flash_cmd_latch.sv
module test_flash_cmd_latch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe;

    always #4 clk = ~clk;

    flash_cmd_latch i_flash_cmd_latch (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    typedef struct {
        logic [15:0] data;
        logic        oe;
        string       tag;
    } exp_t;

    exp_t  sb[$];
    logic  armed = 1'b0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    // monitor: compares after the design's register update
    always @(posedge clk) begin
        #2;
        if (armed && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (dq_out !== e.data || dq_oe !== e.oe) begin
                n_bad++;
                $display("FAIL %s: got data=%h oe=%b, expected data=%h oe=%b",
                         e.tag, dq_out, dq_oe, e.data, e.oe);
            end
        end
    end

    task automatic probe(input logic c, input logic o, input logic w, input logic [11:0] a,
                         input logic [15:0] d, input logic eo, input string tag);
        exp_t e;
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; addr = a;
        e.data = d; e.oe = eo; e.tag = tag;
        sb.push_back(e);
        armed = 1'b1;
        @(negedge clk);
        armed = 1'b0;
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic rd(input logic [11:0] a, input logic [15:0] d, input string tag);
        probe(1'b0, 1'b0, 1'b1, a, d, 1'b1, tag);
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d, input logic gate_n);
        @(negedge clk);
        addr = a; dq_in = {8'h00, d}; ce_n = 1'b0; we_n = 1'b0; oe_n = gate_n;
        @(negedge clk);
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        settle();
    endtask

    task automatic unlock();
        wr(12'h555, 8'hAA, 1'b1);
        wr(12'h2AA, 8'h55, 1'b1);
        wr(12'h555, 8'h90, 1'b1);
    endtask

    // address taken when the later enable falls (R2)
    task automatic wr_late_fall(input logic [11:0] a_early, input logic [11:0] a_late,
                                input logic [7:0] d);
        @(negedge clk);
        addr = a_early; dq_in = {8'h00, d}; we_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        addr = a_late; ce_n = 1'b0;
        @(negedge clk);
        addr = 12'h7C3;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        settle();
    endtask

    // data taken when the earlier enable rises (R3)
    task automatic wr_early_rise(input logic [11:0] a, input logic [7:0] d_pre,
                                 input logic [7:0] d_fin, input logic [7:0] d_post);
        @(negedge clk);
        addr = a; dq_in = {8'h00, d_pre}; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        dq_in = {8'h00, d_fin};
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        dq_in = {8'h00, d_post};
        @(negedge clk);
        we_n = 1'b1;
        settle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R13: idle after reset, nothing driven
        probe(1'b1, 1'b1, 1'b1, 12'h000, 16'h0000, 1'b0, "R13 reset idle");
        // R12: array words
        rd(12'h000, 16'hA500, "R12 array word 0 / R13 array mode");
        rd(12'h003, 16'hA503, "R12 array word 3");
        rd(12'h10F, 16'hA50F, "R12 array index from low bits");
        // R5: gate high while selected
        probe(1'b0, 1'b1, 1'b1, 12'h003, 16'h0000, 1'b0, "R5 gate high hi-z");
        // R4: chip deselected, or write strobe low
        probe(1'b1, 1'b0, 1'b1, 12'h003, 16'h0000, 1'b0, "R4 deselected no drive");
        probe(1'b0, 1'b0, 1'b0, 12'h003, 16'h0000, 1'b0, "R4 write strobe low no drive");

        // R6, R9, R10, R11
        unlock();
        rd(12'h000, 16'h0004, "R9 manufacturer code");
        rd(12'h001, 16'h227E, "R10 device code");
        rd(12'h00E, 16'h2210, "R11 first extended code");
        rd(12'h00F, 16'h2200, "R11 second extended code");
        rd(12'h005, 16'h0000, "R11 other id address");
        rd(12'h801, 16'h0000, "R11 upper bits decoded");

        // R8: exit from any address
        wr(12'h3B7, 8'hF0, 1'b1);
        rd(12'h003, 16'hA503, "R8 exit returns array");

        // R7: broken sequences
        wr(12'h555, 8'hAA, 1'b1);
        wr(12'h2AA, 8'h12, 1'b1);
        wr(12'h555, 8'h90, 1'b1);
        rd(12'h000, 16'hA500, "R7 bad data breaks sequence");
        wr(12'h555, 8'hAA, 1'b1);
        wr(12'h2AA, 8'h55, 1'b1);
        wr(12'h2AA, 8'h90, 1'b1);
        rd(12'h001, 16'hA501, "R7 bad address breaks sequence");
        wr(12'h555, 8'hAA, 1'b1);
        wr(12'h555, 8'hAA, 1'b1);
        wr(12'h2AA, 8'h55, 1'b1);
        wr(12'h555, 8'h90, 1'b1);
        rd(12'h000, 16'hA500, "R7 repeated first step resets");

        // R6: low 11 bits only; upper data byte ignored
        wr(12'hD55, 8'hAA, 1'b1);
        wr(12'h2AA, 8'h55, 1'b1);
        wr(12'h555, 8'h90, 1'b1);
        rd(12'h000, 16'h0004, "R6 upper address bit ignored in match");
        wr(12'h000, 8'hF0, 1'b1);

        // R1: gate low during writes
        wr(12'h555, 8'hAA, 1'b0);
        wr(12'h2AA, 8'h55, 1'b0);
        wr(12'h555, 8'h90, 1'b0);
        rd(12'h000, 16'hA500, "R1 gate low blocks writes");

        // R2: address at the later falling edge
        wr_late_fall(12'h123, 12'h555, 8'hAA);
        wr(12'h2AA, 8'h55, 1'b1);
        wr(12'h555, 8'h90, 1'b1);
        rd(12'h000, 16'h0004, "R2 address from later fall");
        wr(12'h000, 8'hF0, 1'b1);
        wr_late_fall(12'h555, 12'h124, 8'hAA);
        wr(12'h2AA, 8'h55, 1'b1);
        wr(12'h555, 8'h90, 1'b1);
        rd(12'h000, 16'hA500, "R2 early address not used");

        // R3: data at the earlier rising edge
        wr(12'h000, 8'hF0, 1'b1);
        wr_early_rise(12'h555, 8'h55, 8'hAA, 8'h33);
        wr(12'h2AA, 8'h55, 1'b1);
        wr(12'h555, 8'h90, 1'b1);
        rd(12'h001, 16'h227E, "R3 data from earlier rise");
        wr_early_rise(12'h000, 8'hF0, 8'h44, 8'hF0);
        rd(12'h001, 16'h227E, "R3 data before and after rise ignored");

        settle();
        n_chk++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: got %0d pending, expected 0", sb.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule